// File: doc/BRIEF.md
# Arm Top-Submodule Capacitor Voltage Regulator

This block regulates the capacitor voltage of the first submodule in each of six converter arms (upper and lower arm of three phases). Only that one submodule per arm is sensed. The others in the arm are held in order by passive clamping and get no feedback. Once per control period a one-cycle sample strobe arrives. On that strobe each arm's loop forms a target voltage, which is the DC bus voltage shared evenly across the submodules of an arm. The loop subtracts the measured capacitor voltage from the target and runs the difference through a proportional-integral law.

The regulator output is multiplied by the sign of the arm current. A positive current charges an inserted submodule and a negative current discharges it, so the same correction pushes the voltage the right way in both cases. The result is clamped so that adding it to the arm's base modulation value keeps the sum within 0 to 1. It is registered, and it is then added to the first submodule's modulation signal until the next strobe. When the first submodule of an arm is flagged as bypassed during a sample, its current cannot move the capacitor voltage, so that arm's integrator is frozen for that sample.

Voltages are unsigned integers in the ADC's units. Currents are signed. Gains carry 8 fractional bits, so 256 means a gain of 1.0. Modulation values carry 14 fractional bits, so 16384 means 1.0.

Top module: `smbal_top`

## Requirements
- R1: The per-arm voltage target is v_bus divided by n_sm (integer quotient, rounded toward zero). An n_sm of 0 is treated as 1.
- R2: The proportional term is ((target - v_meas) * kp) >>> 8, where >>> is an arithmetic shift that rounds toward minus infinity.
- R3: On each strobe the integrator of a non-bypassed arm adds ((target - v_meas) * ki) >>> 8. The proportional term plus the updated integrator forms the unsigned-sign regulator output.
- R4: After each update, the integrator is saturated to the range [int_lo, int_hi], given as signed 24-bit values with int_lo <= int_hi.
- R5: The regulator output is negated when the arm current is negative. An arm current of exactly zero is treated as positive.
- R6: Each correction is clamped to [-m_base, 16384 - m_base], so that m_base + correction lies in [0, 16384]. This assumes m_base <= 16384.
- R7: The corrections and integrators change only on a clock edge where sample_stb is high, and become visible after that edge. Between strobes the corrections hold, whatever the other inputs do.
- R8: When an arm's top_bypassed bit is set during a strobe, that arm's integrator keeps its value. Its correction still uses the proportional term plus the held integrator.
- R9: The six arms are independent. Arm k uses only bit k or slice k of v_top, i_arm, top_bypassed and m_base, and drives only slice k of corr.
- R10: A synchronous active-high reset clears every integrator and every correction to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | One-cycle strobe that starts a control update |
| n_sm | input | 8 | Submodules per arm (0 treated as 1) |
| v_bus | input | 16 | DC bus voltage, unsigned |
| v_top | input | 96 | Top-submodule capacitor voltages, 16 bits per arm, arm k at [16k+15:16k] |
| i_arm | input | 96 | Arm currents, signed 16 bits per arm |
| top_bypassed | input | 6 | Per-arm flag: top submodule bypassed during this sample |
| m_base | input | 90 | Base modulation per arm, unsigned 15 bits, 16384 = 1.0 |
| kp | input | 12 | Proportional gain, 8 fractional bits |
| ki | input | 12 | Integral gain per sample, 8 fractional bits |
| int_lo | input | 24 | Lower integrator limit, signed |
| int_hi | input | 24 | Upper integrator limit, signed |
| corr | output | 96 | Registered corrections, signed 16 bits per arm |

## Verification
Each arm is given a different voltage error, so a swapped arm or slice shows up as a wrong value. The errors are positive, negative and zero, which separates a wrong sign in the error from a wrong sign selection by current. Pure-proportional runs (ki = 0) and pure-integral runs (kp = 0) are used so that each gain path is seen alone. Repeated strobes with a large error drive the integrator into both limits, and base values near 0 and near 1.0 reach both output clamps. Input changes without a strobe, bypass flags, bus and count values that divide unevenly or are zero, and a mid-run reset show the holding, freezing, target and clearing behaviours.

// File: rtl/smbal_pkg.sv
package smbal_pkg;
    localparam int ARMS     = 6;
    localparam int V_W      = 16;
    localparam int I_W      = 16;
    localparam int N_W      = 8;
    localparam int G_W      = 12;
    localparam int G_FRAC   = 8;
    localparam int ACC_W    = 24;
    localparam int M_FRAC   = 14;
    localparam int M_W      = M_FRAC + 1;
    localparam int C_W      = M_FRAC + 2;
    localparam int X_W      = 32;

    typedef logic signed [X_W-1:0] wide_t;

    function automatic wide_t clamp_w(wide_t x, wide_t lo, wide_t hi);
        if (x < lo)      return lo;
        else if (x > hi) return hi;
        else             return x;
    endfunction

    function automatic wide_t gain_mul(wide_t err, logic [G_W-1:0] g);
        wide_t g_w;
        g_w = wide_t'($signed({1'b0, g}));
        return (err * g_w) >>> G_FRAC;
    endfunction
endpackage

// File: rtl/smbal_ref.sv
module smbal_ref
    import smbal_pkg::*;
#(
    parameter int VW = V_W,
    parameter int NW = N_W
) (
    input  logic [VW-1:0] v_bus,
    input  logic [NW-1:0] n_sm,
    output logic [VW-1:0] v_ref
);
    logic [VW-1:0] div_w;

    assign div_w = (n_sm == '0) ? VW'(1) : VW'(n_sm);
    assign v_ref = v_bus / div_w;
endmodule

// File: rtl/smbal_arm.sv
module smbal_arm
    import smbal_pkg::*;
#(
    parameter int VW = V_W,
    parameter int IW = I_W,
    parameter int GW = G_W,
    parameter int AW = ACC_W,
    parameter int MF = M_FRAC,
    parameter int MW = M_W,
    parameter int CW = C_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stb,
    input  logic [VW-1:0]        v_ref,
    input  logic [VW-1:0]        v_meas,
    input  logic signed [IW-1:0] i_meas,
    input  logic                 bypassed,
    input  logic [MW-1:0]        m_base,
    input  logic [GW-1:0]        kp,
    input  logic [GW-1:0]        ki,
    input  logic signed [AW-1:0] int_lo,
    input  logic signed [AW-1:0] int_hi,
    output logic signed [AW-1:0] integ_q,
    output logic signed [CW-1:0] corr_q
);
    localparam wide_t UNITY = wide_t'(1) <<< MF;

    wide_t err_w, p_w, inc_w, integ_nx, u_w, lo_c, hi_c, corr_nx, base_w;

    always_comb begin
        err_w  = wide_t'($signed({1'b0, v_ref})) - wide_t'($signed({1'b0, v_meas}));
        p_w    = gain_mul(err_w, kp);
        inc_w  = gain_mul(err_w, ki);
        if (bypassed)
            integ_nx = wide_t'(integ_q);
        else
            integ_nx = clamp_w(wide_t'(integ_q) + inc_w, wide_t'(int_lo), wide_t'(int_hi));
        u_w = p_w + integ_nx;
        if (i_meas < 0)
            u_w = -u_w;
        base_w  = wide_t'($signed({1'b0, m_base}));
        lo_c    = -base_w;
        hi_c    = UNITY - base_w;
        corr_nx = clamp_w(u_w, lo_c, hi_c);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            integ_q <= '0;
            corr_q  <= '0;
        end else if (stb) begin
            integ_q <= AW'(integ_nx);
            corr_q  <= CW'(corr_nx);
        end
    end
endmodule

// File: rtl/smbal_top.sv
module smbal_top
    import smbal_pkg::*;
#(
    parameter int NARM = ARMS,
    parameter int VW   = V_W,
    parameter int IW   = I_W,
    parameter int NW   = N_W,
    parameter int GW   = G_W,
    parameter int AW   = ACC_W,
    parameter int MF   = M_FRAC,
    parameter int MW   = M_W,
    parameter int CW   = C_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_stb,
    input  logic [NW-1:0]        n_sm,
    input  logic [VW-1:0]        v_bus,
    input  logic [NARM*VW-1:0]   v_top,
    input  logic [NARM*IW-1:0]   i_arm,
    input  logic [NARM-1:0]      top_bypassed,
    input  logic [NARM*MW-1:0]   m_base,
    input  logic [GW-1:0]        kp,
    input  logic [GW-1:0]        ki,
    input  logic signed [AW-1:0] int_lo,
    input  logic signed [AW-1:0] int_hi,
    output logic [NARM*CW-1:0]   corr
);
    logic [VW-1:0]      v_ref;
    logic [NARM*AW-1:0] integ_flat;

    smbal_ref #(.VW(VW), .NW(NW)) u_ref (
        .v_bus (v_bus),
        .n_sm  (n_sm),
        .v_ref (v_ref)
    );

    for (genvar k = 0; k < NARM; k++) begin : g_arm
        logic signed [AW-1:0] integ_k;
        logic signed [CW-1:0] corr_k;

        smbal_arm #(
            .VW(VW), .IW(IW), .GW(GW), .AW(AW), .MF(MF), .MW(MW), .CW(CW)
        ) u_arm (
            .clk      (clk),
            .rst      (rst),
            .stb      (sample_stb),
            .v_ref    (v_ref),
            .v_meas   (v_top[k*VW +: VW]),
            .i_meas   ($signed(i_arm[k*IW +: IW])),
            .bypassed (top_bypassed[k]),
            .m_base   (m_base[k*MW +: MW]),
            .kp       (kp),
            .ki       (ki),
            .int_lo   (int_lo),
            .int_hi   (int_hi),
            .integ_q  (integ_k),
            .corr_q   (corr_k)
        );

        assign integ_flat[k*AW +: AW] = integ_k;
        assign corr[k*CW +: CW]       = corr_k;
    end
endmodule

// File: rtl/smbal_chk.sv
module smbal_chk
    import smbal_pkg::*;
#(
    parameter int NARM = ARMS,
    parameter int AW   = ACC_W,
    parameter int MF   = M_FRAC,
    parameter int MW   = M_W,
    parameter int CW   = C_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 stb,
    input logic [NARM-1:0]      byp,
    input logic [NARM*MW-1:0]   base,
    input logic signed [AW-1:0] lo,
    input logic signed [AW-1:0] hi,
    input logic [NARM*AW-1:0]   integ,
    input logic [NARM*CW-1:0]   corr
);
    localparam int UNITY = 1 << MF;

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    for (genvar k = 0; k < NARM; k++) begin : g_chk
        // R10
        always_ff @(posedge clk) begin
            if (rst_d) begin
                cleared_chk: assert (corr[k*CW +: CW] == '0 && integ[k*AW +: AW] == '0);
            end
        end

        // R7
        held_chk: assert property (@(posedge clk) disable iff (rst)
            !stb |=> $stable(corr[k*CW +: CW]));

        // R4
        window_chk: assert property (@(posedge clk) disable iff (rst)
            (stb && !byp[k]) |=> ($signed(integ[k*AW +: AW]) >= $past(lo) &&
                                  $signed(integ[k*AW +: AW]) <= $past(hi)));

        // R6
        range_chk: assert property (@(posedge clk) disable iff (rst)
            stb |=> (int'($signed(corr[k*CW +: CW])) + int'($past(base[k*MW +: MW])) >= 0 &&
                     int'($signed(corr[k*CW +: CW])) + int'($past(base[k*MW +: MW])) <= UNITY));

        // R8
        frozen_chk: assert property (@(posedge clk) disable iff (rst)
            (stb && byp[k]) |=> $stable(integ[k*AW +: AW]));
    end
endmodule

bind smbal_top smbal_chk #(
    .NARM(NARM), .AW(AW), .MF(MF), .MW(MW), .CW(CW)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .stb   (sample_stb),
    .byp   (top_bypassed),
    .base  (m_base),
    .lo    (int_lo),
    .hi    (int_hi),
    .integ (integ_flat),
    .corr  (corr)
);

// File: tb/test_smbal_top.sv
module test_smbal_top;
    localparam int NA = 6, VW = 16, IW = 16, NW = 8, GW = 12, AW = 24, MW = 15, CW = 16;
    localparam longint ONE = 16384;

    logic clk = 1'b0, rst = 1'b1, stb = 1'b0;
    logic [NW-1:0] n_sm;
    logic [VW-1:0] v_bus;
    logic [NA*VW-1:0] v_top;
    logic [NA*IW-1:0] i_arm;
    logic [NA-1:0] byp;
    logic [NA*MW-1:0] m_base;
    logic [GW-1:0] kp, ki;
    logic signed [AW-1:0] int_lo, int_hi;
    logic [NA*CW-1:0] corr;

    int vt[NA], ia[NA], bs[NA];
    bit bp[NA];
    int vb, ns, kpr, kir, lor, hir;
    longint mint[NA], expc[NA];
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int k = 0; k < NA; k++) begin
            v_top[k*VW +: VW]  = vt[k][VW-1:0];
            i_arm[k*IW +: IW]  = ia[k][IW-1:0];
            m_base[k*MW +: MW] = bs[k][MW-1:0];
            byp[k]             = bp[k];
        end
        v_bus  = vb[VW-1:0];
        n_sm   = ns[NW-1:0];
        kp     = kpr[GW-1:0];
        ki     = kir[GW-1:0];
        int_lo = lor[AW-1:0];
        int_hi = hir[AW-1:0];
    end

    smbal_top i_smbal_top (
        .clk(clk), .rst(rst), .sample_stb(stb), .n_sm(n_sm), .v_bus(v_bus),
        .v_top(v_top), .i_arm(i_arm), .top_bypassed(byp), .m_base(m_base),
        .kp(kp), .ki(ki), .int_lo(int_lo), .int_hi(int_hi), .corr(corr)
    );

    function automatic longint lim(longint x, longint lo, longint hi);
        return (x < lo) ? lo : (x > hi) ? hi : x;
    endfunction

    // Reference model of one update, written from the requirements
    task automatic model_step();
        longint r, e, p, u;
        r = longint'(vb) / longint'((ns == 0) ? 1 : ns);   // R1
        for (int k = 0; k < NA; k++) begin
            e = r - vt[k];
            p = (e * kpr) >>> 8;                              // R2
            if (!bp[k])                                       // R8
                mint[k] = lim(mint[k] + ((e * kir) >>> 8), lor, hir);  // R3 R4
            u = p + mint[k];
            if (ia[k] < 0) u = -u;                            // R5
            expc[k] = lim(u, -bs[k], ONE - bs[k]);            // R6
        end
    endtask

    task automatic check_all(string tag);
        longint act;
        for (int k = 0; k < NA; k++) begin
            act = longint'($signed(corr[k*CW +: CW]));
            n_chk++;
            if (act !== expc[k]) begin
                n_bad++;
                $display("FAIL %s arm %0d: actual %0d expected %0d", tag, k, act, expc[k]);
            end
        end
    endtask

    task automatic pulse(string tag);
        @(negedge clk);
        model_step();
        stb = 1'b1;
        @(negedge clk);
        stb = 1'b0;
        check_all(tag);
    endtask

    task automatic set_common(int b, int n, int p, int i);
        vb = b; ns = n; kpr = p; kir = i;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < NA; k++) begin mint[k] = 0; expc[k] = 0; end
        check_all("R10 reset");
    endtask

    task automatic t_ref();
        set_common(4000, 4, 256, 0);
        vt = '{900, 1100, 1000, 950, 1200, 400};
        ia = '{1, 1, 1, 1, 1, 1};
        bs = '{8192, 8192, 8192, 8192, 8192, 8192};
        pulse("R1 ref n=4");
        set_common(1000, 3, 256, 0);
        vt = '{300, 333, 340, 320, 200, 500};
        pulse("R1 ref n=3");
        set_common(1000, 0, 256, 0);
        vt = '{990, 1000, 1010, 900, 1100, 0};
        pulse("R1 ref n=0");
    endtask

    task automatic t_prop();
        set_common(6000, 6, 384, 0);
        vt = '{990, 1003, 1000, 1040, 900, 977};
        pulse("R2 prop 1.5");
        kpr = 100;
        pulse("R2 prop frac");
    endtask

    task automatic t_integ();
        lor = -1000000; hir = 1000000;
        set_common(6000, 6, 0, 128);
        vt = '{900, 1100, 1000, 1001, 997, 1050};
        repeat (3) pulse("R3 integ");
        kpr = 256;
        pulse("R3 p plus i");
    endtask

    task automatic t_sat();
        lor = -200; hir = 300;
        set_common(6000, 6, 0, 256);
        vt = '{800, 1200, 900, 1100, 1000, 950};
        bs = '{0, 0, 0, 0, 0, 0};
        ia = '{1, -1, 1, -1, 1, -1};
        repeat (3) pulse("R4 sat");
        vt = '{1200, 800, 1100, 900, 1000, 1150};
        repeat (4) pulse("R4 sat rev");
        lor = -1000000; hir = 1000000;
    endtask

    task automatic t_sign();
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        for (int k = 0; k < NA; k++) mint[k] = 0;
        set_common(6000, 6, 256, 0);
        bs = '{8192, 8192, 8192, 8192, 8192, 8192};
        vt = '{950, 950, 950, 1050, 1050, 1050};
        ia = '{-5, 0, 7, -1, 0, 32767};
        pulse("R5 sign");
    endtask

    task automatic t_clamp();
        set_common(16000, 1, 1024, 0);
        vt = '{0, 15000, 14000, 16000, 15990, 8000};
        ia = '{1, -1, 1, -1, 1, 1};
        bs = '{16000, 16000, 100, 100, 16384, 0};
        pulse("R6 clamp");
    endtask

    task automatic t_hold();
        longint keep[NA];
        for (int k = 0; k < NA; k++) keep[k] = expc[k];
        vt = '{1, 2, 3, 4, 5, 6};
        ia = '{-1, -1, -1, -1, -1, -1};
        vb = 65535; kpr = 4095; kir = 4095;
        repeat (5) @(negedge clk);
        for (int k = 0; k < NA; k++) expc[k] = keep[k];
        check_all("R7 hold");
    endtask

    task automatic t_bypass();
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        for (int k = 0; k < NA; k++) mint[k] = 0;
        lor = -1000000; hir = 1000000;
        set_common(6000, 6, 0, 256);
        bs = '{8192, 8192, 8192, 8192, 8192, 8192};
        ia = '{1, 1, 1, 1, 1, 1};
        vt = '{900, 900, 900, 1100, 1100, 1100};
        pulse("R8 prime");
        bp = '{1, 0, 1, 0, 1, 0};
        kpr = 256;
        pulse("R8 bypass");
        bp = '{0, 0, 0, 0, 0, 0};
        kir = 0;
        vt = '{1000, 1000, 1000, 1000, 1000, 1000};
        pulse("R8 held integ");
    endtask

    task automatic t_indep();
        set_common(6000, 6, 256, 0);
        vt = '{1000, 1000, 1300, 1000, 1000, 1000};
        ia = '{1, 1, -1, 1, 1, 1};
        bs = '{8192, 100, 8192, 8192, 16000, 8192};
        pulse("R9 independent");
    endtask

    task automatic t_reclear();
        rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0;
        for (int k = 0; k < NA; k++) begin mint[k] = 0; expc[k] = 0; end
        check_all("R10 mid reset");
        set_common(6000, 6, 0, 0);
        vt = '{1000, 1000, 1000, 1000, 1000, 1000};
        pulse("R10 integ cleared");
    endtask

    initial begin
        vt = '{1000, 1000, 1000, 1000, 1000, 1000};
        ia = '{1, 1, 1, 1, 1, 1};
        bs = '{8192, 8192, 8192, 8192, 8192, 8192};
        bp = '{0, 0, 0, 0, 0, 0};
        set_common(6000, 6, 0, 0);
        lor = -1000000; hir = 1000000;
        t_reset();
        t_ref();
        t_prop();
        t_integ();
        t_sat();
        t_sign();
        t_clamp();
        t_hold();
        t_bypass();
        t_indep();
        t_reclear();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule